// File: doc/BRIEF.md
# Sequential Next-Line Prefetch Generator

This block watches up to four cache request ports each cycle and turns selected demand events into a short stream of next-line prefetch addresses. A request that misses, or a request that hits a line first brought in by a prefetch, starts a stream. After that, the block offers one candidate address per cycle. Each candidate is the previous address plus one line. The stream ends when its degree count reaches zero. A miss starts a stream of one line. A first use of a prefetched line starts a stream of four lines. A first use also asks the cache, in the same cycle, to clear that line's prefetched mark.

Each cycle the block places its candidate on `cand_addr_o` and raises `cand_valid_o`. The surrounding logic answers in the same cycle with two flags: whether the line is already in the cache (`cand_present_i`) and whether it hits in the recent-prefetch filter (`filt_hit_i`). The candidate becomes a prefetch request on the valid/ready pair `pf_valid_o`/`pf_ready_i` only when both flags are low. Back-pressure rules: a request is offered for exactly one cycle. If `pf_ready_i` is low in that cycle, the request is dropped and not retried, because the stream moves on regardless. `pf_valid_o` never depends on `pf_ready_i`. `filt_ins_o` pulses only on an accepted request, so the filter records only lines that are really on their way.

Top module: `nlp_seq_prefetch`

## Requirements
- R1: Port i triggers when `req_valid_i[i]` is 1 and either `req_hit_i[i]` is 0 (miss) or `req_pf_hit_i[i]` is 1 (first use). A hit with `req_pf_hit_i[i]` at 0 has no effect on the stream.
- R2: `clr_pf_o[i]` is 1 in the same cycle exactly when `req_valid_i[i]`, `req_hit_i[i]` and `req_pf_hit_i[i]` are all 1. The line to clear is the one on port i's address.
- R3: A miss trigger produces one candidate, equal to the trigger address + 64, in the trigger cycle, and none after it.
- R4: A first-use trigger produces four candidates on four consecutive cycles, starting in the trigger cycle. They are the trigger address + 64, +128, +192 and +256, with addresses wrapping modulo 2^32.
- R5: When several ports trigger in one cycle, the highest-numbered one sets the address and the degree. Any trigger replaces a stream already in flight.
- R6: A candidate is offered on `pf_valid_o` only when `cand_present_i` and `filt_hit_i` are both 0. A suppressed candidate still uses up one step of the stream and one unit of degree.
- R7: `filt_ins_o` is 1 exactly in cycles where `pf_valid_o` and `pf_ready_i` are both 1. A request that is not accepted is not offered again.
- R8: After reset, and until the first trigger, `cand_valid_o`, `pf_valid_o` and `filt_ins_o` are 0.
- R9: When no stream is active and no port triggers, `cand_valid_o` and `pf_valid_o` are 0. When `pf_valid_o` is 1, `pf_addr_o` equals `cand_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 4 | Per-port request valid |
| req_addr_i | input | 128 | Per-port byte address, port i in bits [32i+31:32i] |
| req_hit_i | input | 4 | Per-port cache hit flag |
| req_pf_hit_i | input | 4 | Per-port flag: hit line still carries its prefetched mark |
| clr_pf_o | output | 4 | Per-port request to clear the prefetched mark of the hit line |
| cand_valid_o | output | 1 | A candidate is being looked up this cycle |
| cand_addr_o | output | 32 | Candidate next-line address |
| cand_present_i | input | 1 | Candidate line already resides in the cache |
| filt_hit_i | input | 1 | Candidate line hits in the recent-prefetch filter |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_addr_o | output | 32 | Prefetch request address |
| pf_ready_i | input | 1 | Cache accepts the prefetch request this cycle |
| filt_ins_o | output | 1 | Strobe to insert the accepted address into the filter |

## Verification
Assertions check the following on every cycle. Suppression by the presence or filter flags. Clear requests appearing only on hitting ports. The filter strobe appearing only alongside a live request. The one-line stride between consecutive candidates of an uninterrupted stream. The bound on the remaining degree, and that a miss leaves no degree behind. Some behaviour only the bench's scenarios can show: the exact stream length for each trigger type, last-port-wins priority, replacement of a running stream, and that a refused request is dropped rather than retried. The bench shows these by comparing every cycle against a behavioural model under directed and random traffic.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE      = 2'd0,
    TRIG_MISS      = 2'd1,
    TRIG_FIRST_USE = 2'd2
  } trig_kind_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nlp_trigger_sel.sv
module nlp_trigger_sel
  import nlp_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        req_valid_i,
  input  logic [NPORT*ADDR_W-1:0] req_addr_i,
  input  logic [NPORT-1:0]        req_hit_i,
  input  logic [NPORT-1:0]        req_pf_hit_i,
  output logic [NPORT-1:0]        clr_pf_o,
  output trig_kind_e              trig_kind_o,
  output logic [ADDR_W-1:0]       trig_addr_o
);

  logic [NPORT-1:0] is_miss;
  logic [NPORT-1:0] is_first_use;

  // Per-port event decode
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign is_miss[p]      = req_valid_i[p] && !req_hit_i[p];
    assign is_first_use[p] = req_valid_i[p] && req_hit_i[p] && req_pf_hit_i[p];
    assign clr_pf_o[p]     = is_first_use[p];

    // R2: a clear request only ever accompanies a valid hit
    p_clr_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pf_o[p] |-> (req_valid_i[p] && req_hit_i[p]));
  end

  // Ascending scan: a later triggering port overwrites an earlier one
  always_comb begin
    trig_kind_o = TRIG_NONE;
    trig_addr_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (is_miss[p]) begin
        trig_kind_o = TRIG_MISS;
        trig_addr_o = req_addr_i[p*ADDR_W +: ADDR_W];
      end else if (is_first_use[p]) begin
        trig_kind_o = TRIG_FIRST_USE;
        trig_addr_o = req_addr_i[p*ADDR_W +: ADDR_W];
      end
    end
  end

  // R1: plain hits without prefetched mark never trigger
  p_plain_hit_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid_i & ~(req_hit_i & ~req_pf_hit_i)) == '0) |-> (trig_kind_o == TRIG_NONE));

endmodule

// File: rtl/nlp_stream_gen.sv
module nlp_stream_gen
  import nlp_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LINE_BYTES    = 64,
  parameter int MISS_DEG      = 1,
  parameter int FIRST_USE_DEG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trig_kind_e        trig_kind_i,
  input  logic [ADDR_W-1:0] trig_addr_i,
  output logic              cand_valid_o,
  output logic [ADDR_W-1:0] cand_addr_o
);

  localparam int MAX_DEG = max_int(MISS_DEG, FIRST_USE_DEG);
  localparam int DEG_W   = $clog2(MAX_DEG + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LINE_BYTES);

  logic [ADDR_W-1:0] last_q;
  logic [DEG_W-1:0]  deg_q;
  logic [ADDR_W-1:0] eff_last;
  logic [DEG_W-1:0]  eff_deg;

  // A trigger takes effect in the generation step of its own cycle
  always_comb begin
    unique case (trig_kind_i)
      TRIG_MISS: begin
        eff_last = trig_addr_i;
        eff_deg  = DEG_W'(MISS_DEG);
      end
      TRIG_FIRST_USE: begin
        eff_last = trig_addr_i;
        eff_deg  = DEG_W'(FIRST_USE_DEG);
      end
      default: begin
        eff_last = last_q;
        eff_deg  = deg_q;
      end
    endcase
  end

  assign cand_valid_o = (eff_deg != '0);
  assign cand_addr_o  = eff_last + STEP;

  // Stream advances every active cycle, issued or not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      deg_q  <= '0;
    end else if (cand_valid_o) begin
      last_q <= cand_addr_o;
      deg_q  <= eff_deg - 1'b1;
    end
  end

  // R4: remaining degree never exceeds the largest load
  p_deg_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    deg_q <= DEG_W'(MAX_DEG));

  // R3: a miss leaves only MISS_DEG-1 steps behind
  p_miss_deg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_kind_i == TRIG_MISS) |=> (deg_q == DEG_W'(MISS_DEG - 1)));

  // R4: uninterrupted stream steps by one line
  p_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid_o && trig_kind_i == TRIG_NONE && $past(cand_valid_o))
      |-> (cand_addr_o == $past(cand_addr_o) + STEP));

  // R9: idle state with no trigger offers nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (deg_q == '0 && trig_kind_i == TRIG_NONE) |-> !cand_valid_o);

endmodule

// File: rtl/nlp_issue_gate.sv
module nlp_issue_gate #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid_i,
  input  logic [ADDR_W-1:0] cand_addr_i,
  input  logic              cand_present_i,
  input  logic              filt_hit_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_ready_i,
  output logic              filt_ins_o
);

  logic drop;

  assign drop       = cand_present_i || filt_hit_i;
  assign pf_valid_o = cand_valid_i && !drop;
  assign pf_addr_o  = cand_addr_i;
  assign filt_ins_o = pf_valid_o && pf_ready_i;

  // R6: present or filtered lines are never requested
  p_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_present_i || filt_hit_i) |-> !pf_valid_o);

  // R7: filter insert only for a request on a lookup with no hit
  p_ins_needs_lookup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    filt_ins_o |-> (cand_valid_i && !cand_present_i && !filt_hit_i));

  // R9: no request without a candidate
  p_req_needs_cand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid_o |-> cand_valid_i);

endmodule

// File: rtl/nlp_seq_prefetch.sv
module nlp_seq_prefetch
  import nlp_pkg::*;
#(
  parameter int NPORT         = 4,
  parameter int ADDR_W        = 32,
  parameter int LINE_BYTES    = 64,
  parameter int MISS_DEG      = 1,
  parameter int FIRST_USE_DEG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        req_valid_i,
  input  logic [NPORT*ADDR_W-1:0] req_addr_i,
  input  logic [NPORT-1:0]        req_hit_i,
  input  logic [NPORT-1:0]        req_pf_hit_i,
  output logic [NPORT-1:0]        clr_pf_o,
  output logic                    cand_valid_o,
  output logic [ADDR_W-1:0]       cand_addr_o,
  input  logic                    cand_present_i,
  input  logic                    filt_hit_i,
  output logic                    pf_valid_o,
  output logic [ADDR_W-1:0]       pf_addr_o,
  input  logic                    pf_ready_i,
  output logic                    filt_ins_o
);

  trig_kind_e        trig_kind;
  logic [ADDR_W-1:0] trig_addr;

  nlp_trigger_sel #(
    .NPORT  (NPORT),
    .ADDR_W (ADDR_W)
  ) u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_hit_i    (req_hit_i),
    .req_pf_hit_i (req_pf_hit_i),
    .clr_pf_o     (clr_pf_o),
    .trig_kind_o  (trig_kind),
    .trig_addr_o  (trig_addr)
  );

  nlp_stream_gen #(
    .ADDR_W        (ADDR_W),
    .LINE_BYTES    (LINE_BYTES),
    .MISS_DEG      (MISS_DEG),
    .FIRST_USE_DEG (FIRST_USE_DEG)
  ) u_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_kind_i  (trig_kind),
    .trig_addr_i  (trig_addr),
    .cand_valid_o (cand_valid_o),
    .cand_addr_o  (cand_addr_o)
  );

  nlp_issue_gate #(
    .ADDR_W (ADDR_W)
  ) u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .cand_valid_i   (cand_valid_o),
    .cand_addr_i    (cand_addr_o),
    .cand_present_i (cand_present_i),
    .filt_hit_i     (filt_hit_i),
    .pf_valid_o     (pf_valid_o),
    .pf_addr_o      (pf_addr_o),
    .pf_ready_i     (pf_ready_i),
    .filt_ins_o     (filt_ins_o)
  );

  // R7: insert strobe is tied to a live request on this cycle
  p_ins_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    filt_ins_o |-> (pf_valid_o && pf_ready_i));

  // R9: request address mirrors the candidate
  p_addr_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid_o |-> (pf_addr_o == cand_addr_o));

endmodule

// File: tb/nlp_seq_prefetch_test.sv
module nlp_seq_prefetch_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0;
  logic [NP*32-1:0] req_addr = '0;
  logic [NP-1:0] req_hit = '0;
  logic [NP-1:0] req_pf_hit = '0;
  logic [NP-1:0] clr_pf;
  logic          cand_valid;
  logic [31:0]   cand_addr;
  logic          cand_present = 1'b0;
  logic          filt_hit = 1'b0;
  logic          pf_valid;
  logic [31:0]   pf_addr;
  logic          pf_ready = 1'b1;
  logic          filt_ins;

  int n_checks = 0;
  int n_fail = 0;
  int m_deg = 0;
  logic [31:0] m_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nlp_seq_prefetch uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid_i (req_valid), .req_addr_i (req_addr),
    .req_hit_i (req_hit), .req_pf_hit_i (req_pf_hit),
    .clr_pf_o (clr_pf),
    .cand_valid_o (cand_valid), .cand_addr_o (cand_addr),
    .cand_present_i (cand_present), .filt_hit_i (filt_hit),
    .pf_valid_o (pf_valid), .pf_addr_o (pf_addr),
    .pf_ready_i (pf_ready), .filt_ins_o (filt_ins)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_port(input int p, input bit v, input logic [31:0] a,
                          input bit h, input bit ph);
    req_valid[p] = v;
    req_addr[p*32 +: 32] = a;
    req_hit[p] = h;
    req_pf_hit[p] = ph;
  endtask

  task automatic clear_ports();
    req_valid = '0; req_hit = '0; req_pf_hit = '0; req_addr = '0;
  endtask

  // Inputs are set just after a falling edge; check, advance model, move on
  task automatic step(input string tag);
    int eff_deg;
    logic [31:0] eff_last;
    logic [31:0] exp_cand;
    bit exp_cv, exp_pv, exp_ins;
    logic [NP-1:0] exp_clr;
    #1;
    eff_deg = m_deg;
    eff_last = m_last;
    exp_clr = '0;
    for (int p = 0; p < NP; p++) begin
      if (req_valid[p] && !req_hit[p]) begin
        eff_deg = 1; eff_last = req_addr[p*32 +: 32];
      end else if (req_valid[p] && req_hit[p] && req_pf_hit[p]) begin
        eff_deg = 4; eff_last = req_addr[p*32 +: 32];
        exp_clr[p] = 1'b1;
      end
    end
    exp_cv = (eff_deg != 0);
    exp_cand = eff_last + 32'd64;
    exp_pv = exp_cv && !cand_present && !filt_hit;
    exp_ins = exp_pv && pf_ready;
    chk(clr_pf == exp_clr, tag, "clr_pf", 32'(clr_pf), 32'(exp_clr));
    chk(cand_valid == exp_cv, tag, "cand_valid", 32'(cand_valid), 32'(exp_cv));
    if (exp_cv) chk(cand_addr == exp_cand, tag, "cand_addr", cand_addr, exp_cand);
    chk(pf_valid == exp_pv, tag, "pf_valid", 32'(pf_valid), 32'(exp_pv));
    if (exp_pv) chk(pf_addr == exp_cand, tag, "pf_addr", pf_addr, exp_cand);
    chk(filt_ins == exp_ins, tag, "filt_ins", 32'(filt_ins), 32'(exp_ins));
    if (exp_cv) begin
      m_last = exp_cand;
      m_deg = eff_deg - 1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: quiet after reset
    step("R8"); step("R8");

    // R3: miss on port 0 gives one line then stops
    set_port(0, 1, 32'h0000_1000, 0, 0); step("R3");
    clear_ports(); step("R3"); step("R3");

    // R4 and R2: first use gives four lines and a clear request
    set_port(1, 1, 32'h0000_2040, 1, 1); step("R2");
    clear_ports(); step("R4"); step("R4"); step("R4"); step("R4"); step("R4");

    // R4: wrap modulo 2^32
    set_port(2, 1, 32'hFFFF_FF80, 1, 1); step("R4");
    clear_ports(); repeat (4) step("R4");

    // R1: plain hit, and pf flag on a miss, do not start a first-use stream
    set_port(0, 1, 32'h0000_3000, 1, 0); step("R1");
    clear_ports(); step("R1");
    set_port(3, 1, 32'h0000_3100, 0, 1); step("R1");
    clear_ports(); step("R1"); step("R1");

    // R5: port 3 wins over port 0; then a miss replaces a running stream
    set_port(0, 1, 32'h0000_4000, 1, 1);
    set_port(3, 1, 32'h0000_5000, 0, 0); step("R5");
    clear_ports(); step("R5");
    set_port(2, 1, 32'h0000_6000, 1, 1); step("R5");
    clear_ports(); step("R5");
    set_port(1, 1, 32'h0000_7000, 0, 0); step("R5");
    clear_ports(); step("R5"); step("R5");

    // R6: suppressed candidates still consume the stream
    set_port(0, 1, 32'h0000_8000, 1, 1); cand_present = 1; step("R6");
    clear_ports(); cand_present = 0; filt_hit = 1; step("R6");
    filt_hit = 0; step("R6"); step("R6"); step("R6");

    // R7: refused request is dropped, no insert, not retried
    set_port(0, 1, 32'h0000_9000, 1, 1); pf_ready = 0; step("R7");
    clear_ports(); step("R7"); pf_ready = 1; step("R7"); step("R7"); step("R7");

    // R9: random traffic compared cycle by cycle
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < NP; p++)
        set_port(p, ($urandom % 6) == 0,
                 (($urandom % 8) == 0) ? (32'hFFFF_FF00 | ($urandom & 32'hFF)) : $urandom,
                 $urandom % 2, $urandom % 2);
      cand_present = ($urandom % 4) == 0;
      filt_hit = ($urandom % 4) == 0;
      pf_ready = ($urandom % 3) != 0;
      step("R9");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule